// File: doc/BRIEF.md
# CAN Receive Bit Sampling Timer

This block sits behind a synchroniser on the CAN receive line and runs from an oversampling clock. It turns the level stream into one sampled bit per nominal bit time. Each sampled bit comes out as a single-cycle strobe that carries the bit value and the raw bit index of that bit. The raw index counts stuff bits too, because the block does not know the frame structure. The bit period and the sample-point position come from configuration inputs as whole sample-clock cycles. A sample point of 70% of the bit time is the usual choice, for example a period of 10 with an offset of 7.

While idle, the block waits for a dominant (low) level. That instant is both the start of frame and the first timing anchor. From then on, the sample instant of raw bit n is the anchor time, plus the period times (n minus the bit index held at the anchor), plus the offset. Every recessive-to-dominant transition during reception moves the anchor to that cycle and to the current raw index. This is a hard resynchronisation, so a transmitter running slightly fast or slow is still sampled near the intended point. A frame parser downstream pulses the frame-done input to send the sampler back to idle.

Top module: `canBitSampler`

## Requirements
- R1: After reset the block is idle: `busy` is 0, `bitValid` is 0 and `bitIndex` is 0.
- R2: While idle with a valid configuration, a clock edge that sees `rxIn` low (0 = dominant, 1 = recessive) starts reception. `busy` is 1 after that edge. Raw bit 0 is sampled `cfgOffset` cycles after that edge, and its strobe appears one cycle after the sampling edge.
- R3: With no falling edge in between, consecutive samples are exactly `cfgPeriod` cycles apart. `bitValue` equals `rxIn` at the sampling edge.
- R4: A 1-to-0 transition of `rxIn` during reception re-anchors timing. The next sample is taken `cfgOffset` cycles after the edge that sees the transition.
- R5: A 0-to-1 transition of `rxIn` has no effect on sample timing.
- R6: A configuration with `cfgPeriod` equal to 0, or with `cfgOffset` not below `cfgPeriod`, is rejected. The block stays idle and gives no strobe, even while `rxIn` is low.
- R7: Configuration is captured while idle. Changes to `cfgPeriod` or `cfgOffset` during reception do not affect timing.
- R8: A `frameDone` pulse during reception returns the block to idle after that edge. It takes no sample at that edge and clears the raw index, so the next frame starts again at index 0.
- R9: An offset of 0 is legal. The sample is then taken on the anchoring edge itself.
- R10: Each raw index is strobed at most once. Strobed indices in a frame run 0, 1, 2, … with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxIn | input | 1 | Synchronised receive line, 0 dominant, 1 recessive |
| cfgPeriod | input | PERIOD_W | Bit period in clock cycles |
| cfgOffset | input | PERIOD_W | Sample-point offset in clock cycles from the anchor |
| frameDone | input | 1 | Frame-end pulse from the parser, returns the block to idle |
| bitValid | output | 1 | One-cycle strobe for a sampled bit |
| bitValue | output | 1 | Sampled line level, valid with `bitValid` |
| bitIndex | output | INDEX_W | Raw bit index of the sampled bit, stuff bits included |
| busy | output | 1 | High while a frame is being received |

## Verification
The assertions assume the configuration pins are valid at the moment reception starts. They also assume `frameDone` comes only from a parser that has seen the frame, so it is never used as a way to hold the line idle. The bench keeps the frame-done pulse on a recessive cycle after the frame's trailing recessive bits.

The sweep covers every period from 2 to 7 and every offset below each period. Each combination runs three line bit lengths: one cycle shorter than, equal to, and one cycle longer than the configured period. Resynchronisation is therefore exercised on both early and late edges. A bench model computes every expected sample instant directly from the anchor-plus-multiple formula.

// File: rtl/canBitPkg.sv
package canBitPkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RECV = 1'b1
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // idle: capture configuration
    logic start;   // start of frame on this edge
    logic anchor;  // timing reference moves to this edge
    logic clear;   // frame finished, drop counters
    logic run;     // receiving
  } ctlStrobe_t;

endpackage

// File: rtl/canBitCtl.sv
module canBitCtl
  import canBitPkg::*;
#(
  parameter int PERIOD_W = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxIn,
  input  logic                rxPrev,
  input  logic                frameDone,
  input  logic [PERIOD_W-1:0] cfgPeriod,
  input  logic [PERIOD_W-1:0] cfgOffset,
  output ctlStrobe_t          ctl,
  output logic                busy
);

  rxState_t state;
  rxState_t stateNext;
  logic     cfgOk;

  assign cfgOk = (cfgPeriod != '0) && (cfgOffset < cfgPeriod);
  assign busy  = (state == ST_RECV);

  always_comb begin
    ctl       = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        ctl.load  = 1'b1;
        ctl.clear = frameDone;
        if (!frameDone && !rxIn && cfgOk) begin
          ctl.start  = 1'b1;
          ctl.anchor = 1'b1;
          stateNext  = ST_RECV;
        end
      end
      default: begin
        ctl.run = 1'b1;
        if (frameDone) begin
          ctl.clear = 1'b1;
          stateNext = ST_IDLE;
        end else if (rxPrev && !rxIn) begin
          ctl.anchor = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && busy) |=> !busy); // R8

  AST_START_ON_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !$past(rxIn)); // R2

endmodule

// File: rtl/canBitDp.sv
module canBitDp
  import canBitPkg::*;
#(
  parameter int PERIOD_W = 10,
  parameter int INDEX_W  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxIn,
  input  ctlStrobe_t          ctl,
  input  logic [PERIOD_W-1:0] cfgPeriod,
  input  logic [PERIOD_W-1:0] cfgOffset,
  output logic                rxPrev,
  output logic                bitValid,
  output logic                bitValue,
  output logic [INDEX_W-1:0]  bitIndex
);

  localparam logic [PERIOD_W-1:0] P_ONE   = PERIOD_W'(1);
  localparam logic [INDEX_W-1:0]  I_ONE   = INDEX_W'(1);
  localparam int                  GAP_W   = PERIOD_W + 1;
  localparam logic [GAP_W-1:0]    GAP_ONE = GAP_W'(1);

  logic [PERIOD_W-1:0] periodQ, offsetQ;
  logic [PERIOD_W-1:0] perEff, offEff;
  logic [PERIOD_W-1:0] phase, phaseNow;
  logic [INDEX_W-1:0]  curIdx;
  logic                active, sampleNow;

  // use the pins directly on the start edge so a late change is not missed
  assign perEff    = ctl.load ? cfgPeriod : periodQ;
  assign offEff    = ctl.load ? cfgOffset : offsetQ;
  assign phaseNow  = ctl.anchor ? '0 : phase;
  assign active    = ctl.start | (ctl.run & ~ctl.clear);
  assign sampleNow = active && (phaseNow == offEff);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodQ <= '0;
      offsetQ <= '0;
    end else if (ctl.load) begin
      periodQ <= cfgPeriod;
      offsetQ <= cfgOffset;
    end
  end

  // cycles since anchor, modulo the period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        phase <= '0;
    else if (!active)                 phase <= '0;
    else if (phaseNow == perEff - P_ONE) phase <= '0;
    else                              phase <= phaseNow + P_ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  curIdx <= '0;
    else if (ctl.clear)         curIdx <= '0;
    else if (sampleNow)         curIdx <= curIdx + I_ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxPrev   <= 1'b1;
      bitValid <= 1'b0;
      bitValue <= 1'b1;
      bitIndex <= '0;
    end else begin
      rxPrev   <= rxIn;
      bitValid <= sampleNow;
      if (sampleNow) begin
        bitValue <= rxIn;
        bitIndex <= curIdx;
      end else if (ctl.clear) begin
        bitIndex <= '0;
      end
    end
  end

  // ---- checking state for the assertions below ----
  logic [GAP_W-1:0]   gap;
  logic               havePrev, anchorSeen;
  logic [INDEX_W-1:0] lastOutIdx;
  logic               seenOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gap        <= '0;
      havePrev   <= 1'b0;
      anchorSeen <= 1'b0;
    end else if (!active) begin
      havePrev   <= 1'b0;
      anchorSeen <= 1'b0;
    end else if (sampleNow) begin
      gap        <= GAP_ONE;
      havePrev   <= 1'b1;
      anchorSeen <= 1'b0;
    end else begin
      if (gap != '1) gap <= gap + GAP_ONE;
      anchorSeen <= anchorSeen | ctl.anchor;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastOutIdx <= '0;
      seenOut    <= 1'b0;
    end else if (ctl.clear) begin
      seenOut    <= 1'b0;
    end else if (bitValid) begin
      lastOutIdx <= bitIndex;
      seenOut    <= 1'b1;
    end
  end

  AST_PERIOD_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (sampleNow && havePrev && !anchorSeen && !ctl.anchor) |-> (gap == GAP_W'(periodQ))); // R3

  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && seenOut) |-> (bitIndex == lastOutIdx + I_ONE)); // R10

  AST_FIRST_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    (bitValid && !seenOut) |-> (bitIndex == '0)); // R2

  AST_RUN_CFG_OK: assert property (@(posedge clk) disable iff (!rstN)
    ctl.run |-> ((periodQ != '0) && (offsetQ < periodQ))); // R6

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rstN)
    ctl.run |=> ($stable(periodQ) && $stable(offsetQ))); // R7

endmodule

// File: rtl/canBitSampler.sv
module canBitSampler
  import canBitPkg::*;
#(
  parameter int PERIOD_W = 10,
  parameter int INDEX_W  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxIn,
  input  logic [PERIOD_W-1:0] cfgPeriod,
  input  logic [PERIOD_W-1:0] cfgOffset,
  input  logic                frameDone,
  output logic                bitValid,
  output logic                bitValue,
  output logic [INDEX_W-1:0]  bitIndex,
  output logic                busy
);

  ctlStrobe_t ctl;
  logic       rxPrev;

  canBitCtl #(.PERIOD_W(PERIOD_W)) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .rxIn      (rxIn),
    .rxPrev    (rxPrev),
    .frameDone (frameDone),
    .cfgPeriod (cfgPeriod),
    .cfgOffset (cfgOffset),
    .ctl       (ctl),
    .busy      (busy)
  );

  canBitDp #(.PERIOD_W(PERIOD_W), .INDEX_W(INDEX_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .rxIn      (rxIn),
    .ctl       (ctl),
    .cfgPeriod (cfgPeriod),
    .cfgOffset (cfgOffset),
    .rxPrev    (rxPrev),
    .bitValid  (bitValid),
    .bitValue  (bitValue),
    .bitIndex  (bitIndex)
  );

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy)) |-> !bitValid); // R6

endmodule

// File: tb/canBitSampler_bench.sv
`timescale 1ns/1ps
module canBitSampler_bench;

  localparam int PW = 10;
  localparam int IW = 8;
  localparam int NBITS = 18;
  localparam logic [NBITS-1:0] PATTERN = 18'b0_1100010_11111_01001; // sent MSB first

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          rxIn = 1'b1;
  logic [PW-1:0] cfgPeriod = '0;
  logic [PW-1:0] cfgOffset = '0;
  logic          frameDone = 1'b0;
  logic          bitValid, bitValue, busy;
  logic [IW-1:0] bitIndex;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  // bench reference state
  int  mRecv = 0, mPrev = 1, mAT = 0, mAI = 0, mCur = 0;
  int  mAnch = 0, mRise = 0;

  always #2.5 clk = ~clk;

  canBitSampler #(.PERIOD_W(PW), .INDEX_W(IW)) u_canBitSampler (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .cfgPeriod(cfgPeriod), .cfgOffset(cfgOffset),
    .frameDone(frameDone), .bitValid(bitValid), .bitValue(bitValue),
    .bitIndex(bitIndex), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one frame: line bits of lineLen cycles, sampler set to per/off
  task automatic runFrame(input int per, input int off, input int lineLen, input bit midChange);
    int lead  = 3;
    int nCyc  = lead + NBITS * lineLen + 2 * lineLen + 2;
    for (int c = 0; c < nCyc; c++) begin
      int  line;
      bit  done, exp;
      int  expIdx;
      string tag;
      line = 1;
      if (c >= lead && c < lead + NBITS * lineLen)
        line = PATTERN[NBITS - 1 - (c - lead) / lineLen];
      done = (c == nCyc - 1);
      @(negedge clk);
      rxIn      = line[0];
      frameDone = done;
      if (c == 0) begin
        cfgPeriod = PW'(per);
        cfgOffset = PW'(off);
      end
      if (midChange && c == lead + 2) begin
        cfgPeriod = PW'(per + 3);
        cfgOffset = PW'(0);
      end
      @(posedge clk);
      exp = 0; expIdx = 0;
      if (done) begin
        mRecv = 0; mCur = 0;
      end else if (mRecv == 0) begin
        if (line == 0) begin
          mRecv = 1; mAT = c; mAI = 0; mCur = 0; mAnch = 1; mRise = 0;
        end
      end else if (mPrev == 1 && line == 0) begin
        mAT = c; mAI = mCur; mAnch = 1;
      end else if (mPrev == 0 && line == 1) begin
        mRise = 1;
      end
      if (mRecv == 1 && !done && c == mAT + per * (mCur - mAI) + off) begin
        exp = 1; expIdx = mCur; mCur++;
      end
      mPrev = line;
      #1;
      if (exp) begin
        if (midChange)        tag = "R7";
        else if (expIdx == 0) tag = "R2";
        else if (off == 0)    tag = "R9";
        else if (mAnch)       tag = "R4";
        else if (mRise)       tag = "R5";
        else                  tag = "R3";
        mAnch = 0; mRise = 0;
        chk(bitValid == 1'b1, {tag, " strobe"}, bitValid, 1);
        chk(bitValue == line[0], {tag, " value"}, bitValue, line);
        chk(int'(bitIndex) == expIdx, "R10 index", bitIndex, expIdx);
      end else begin
        chk(bitValid == 1'b0, "R10 no extra strobe", bitValid, 0);
      end
      chk(busy == mRecv[0], done ? "R8 busy after done" : "R2 busy", busy, mRecv);
    end
    @(negedge clk);
    frameDone = 1'b0;
    #1;
    chk(int'(bitIndex) == 0, "R8 index cleared", bitIndex, 0);
  endtask

  task automatic badCfg(input int per, input int off);
    @(negedge clk);
    cfgPeriod = PW'(per);
    cfgOffset = PW'(off);
    rxIn = 1'b0;
    for (int c = 0; c < 12; c++) begin
      @(posedge clk); #1;
      chk(busy == 1'b0, "R6 stays idle", busy, 0);
      chk(bitValid == 1'b0, "R6 no strobe", bitValid, 0);
    end
    @(negedge clk);
    rxIn = 1'b1;
    @(posedge clk);
    mPrev = 1;
  endtask

  initial begin
    #900us;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(busy == 1'b0, "R1 busy in reset", busy, 0);
    chk(bitValid == 1'b0, "R1 valid in reset", bitValid, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(bitValid == 1'b0, "R1 valid", bitValid, 0);
    chk(int'(bitIndex) == 0, "R1 index", bitIndex, 0);

    badCfg(0, 0);
    badCfg(4, 4);
    badCfg(4, 7);

    for (int per = 2; per <= 7; per++)
      for (int off = 0; off < per; off++)
        for (int d = -1; d <= 1; d++)
          runFrame(per, off, per + d, 1'b0);

    runFrame(5, 2, 5, 1'b1);
    runFrame(6, 4, 7, 1'b1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule